// File: doc/BRIEF.md
# Virtual supervisor top interrupt reporter

This combinational unit reports which interrupt a guest running in virtual supervisor mode should take next, and at what priority. It combines the pending, enable and hypervisor delegation vectors into a set of enabled guest interrupts. It then either picks a winner by a fixed default ordering, or applies an override set by the hypervisor that injects an interrupt identity and priority of its choosing. The result is one read-only word: an identity field and a priority field.

The reporter has no storage and no write path. A register read returns the current value of `top_o`, and a write to that register has no effect because nothing in the unit can be written. The override can place the injected interrupt relative to the default ordering. In that case a real guest external interrupt wins over the injected one, and an injected zero priority is reported as the lowest priority value.

Top module: `vs_top_irq_report`

## Requirements
- R1: The enabled set is `(pend_i & enbl_i & deleg_i) >> 1`. Input bit i+1 maps to position i, and input bit 0 never affects the result. A bit that is pending but not enabled, or not delegated, is not in the set.
- R2: With `force_en_i`=0, the winner is chosen by default order, from highest to lowest:
  - positions 11, 3, 7, 9, 1, 5, 13;
  - then every other position, in ascending index order.
  
  The reported identity is the winner's position index.
- R3: With `force_en_i`=0 and an empty enabled set, `top_o` is all zeros.
- R4: With `force_en_i`=0, the computed priority is the external priority (R5) when the identity is 9, and 255 otherwise.
- R5: The external priority is `force_prio_i` when all three of these hold: `guest_ext_sel_i`=0, `force_id_i`=9 and `force_prio_i`≠0. Otherwise it is 255.
- R6: With `force_en_i`=1, `top_o` is all zeros when position 9 is not in the enabled set and `force_id_i`=9.
- R7: With `force_en_i`=1, the identity is 9 when position 9 is enabled and either `force_id_i`=9 or `dflt_rel_i`=1. Otherwise the identity is `force_id_i`.
- R8: With `force_en_i`=1, the computed priority is the external priority (R5) when the identity is 9. Otherwise it is `force_prio_i` when `force_prio_i`≠0 or `dflt_rel_i`=0, and 255 when `force_prio_i`=0 with `dflt_rel_i`=1.
- R9: When `top_o` is not zero:
  - `top_o[27:16]` holds the identity;
  - `top_o[7:0]` holds the computed priority when `prio_mode_i`=1, and 1 when `prio_mode_i`=0;
  - all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | 64 | Pending interrupt vector |
| enbl_i | input | 64 | Interrupt enable vector |
| deleg_i | input | 64 | Hypervisor delegation vector |
| force_en_i | input | 1 | Override enable: inject the identity in `force_id_i` |
| force_id_i | input | 12 | Injected interrupt identity |
| dflt_rel_i | input | 1 | Place the injected interrupt relative to the default order |
| prio_mode_i | input | 1 | Report the computed priority (1) or the constant 1 (0) |
| force_prio_i | input | 8 | Injected priority |
| guest_ext_sel_i | input | 6 | Guest external interrupt selector |
| top_o | output | 64 | Identity/priority word |

## Verification
The bench sweeps every single enabled position and every pair among the low sixteen positions. A wrong ordering table would report the lower-ranked member of a pair. A reporter that ignored the one-bit shift would name a position one too high. A reporter that dropped the delegation term would show an interrupt that was only pending and enabled.

The override sweep crosses these inputs:
- every injected identity class, with and without position 9 enabled;
- zero and nonzero injected priorities;
- both placement modes;
- both selector cases.

That sweep catches three kinds of fault. A reporter that forgot the all-zero result for an absent external interrupt would report identity 9. One that mishandled the zero-priority rule would report 0 instead of 255. One that ignored the selector would return the injected priority where 255 is due.

// File: rtl/vs_top_irq_report.sv
module vs_top_irq_report #(
  parameter int NIRQ    = 64,
  parameter int IDW     = 12,
  parameter int PRW     = 8,
  parameter int SELW    = 6,
  parameter int OUTW    = 64,
  parameter int ID_LSB  = 16,
  parameter int EXT_POS = 9
) (
  input  logic [NIRQ-1:0] pend_i,
  input  logic [NIRQ-1:0] enbl_i,
  input  logic [NIRQ-1:0] deleg_i,
  input  logic            force_en_i,
  input  logic [IDW-1:0]  force_id_i,
  input  logic            dflt_rel_i,
  input  logic            prio_mode_i,
  input  logic [PRW-1:0]  force_prio_i,
  input  logic [SELW-1:0] guest_ext_sel_i,
  output logic [OUTW-1:0] top_o
);

  localparam int FIXN = 7;
  localparam int FIXL [FIXN] = '{11, 3, 7, 9, 1, 5, 13};
  localparam logic [PRW-1:0] PR_LOW = '1;
  localparam logic [IDW-1:0] EXT_ID = IDW'(EXT_POS);

  function automatic logic in_fixed(input int p);
    logic r;
    r = 1'b0;
    for (int k = 0; k < FIXN; k++)
      if (FIXL[k] == p) r = 1'b1;
    return r;
  endfunction

  logic [NIRQ-1:0] enab;
  logic [IDW-1:0]  win;
  logic            found;
  logic [PRW-1:0]  ext_pr;
  logic [IDW-1:0]  ident;
  logic [PRW-1:0]  pr;
  logic            zero_out;
  logic [OUTW-1:0] res;

  always_comb begin
    enab = (pend_i & enbl_i & deleg_i) >> 1;

    found = 1'b0;
    win   = '0;
    for (int k = 0; k < FIXN; k++)
      if (!found && enab[FIXL[k]]) begin
        win   = IDW'(FIXL[k]);
        found = 1'b1;
      end
    for (int i = 0; i < NIRQ; i++)
      if (!found && enab[i] && !in_fixed(i)) begin
        win   = IDW'(i);
        found = 1'b1;
      end

    ext_pr = (guest_ext_sel_i == '0 && force_id_i == EXT_ID && force_prio_i != '0)
             ? force_prio_i : PR_LOW;

    if (force_en_i) begin
      zero_out = !enab[EXT_POS] && force_id_i == EXT_ID;
      ident    = (enab[EXT_POS] && (force_id_i == EXT_ID || dflt_rel_i)) ? EXT_ID : force_id_i;
      pr       = (ident == EXT_ID) ? ext_pr
               : ((force_prio_i != '0 || !dflt_rel_i) ? force_prio_i : PR_LOW);
    end else begin
      zero_out = !found;
      ident    = win;
      pr       = (ident == EXT_ID) ? ext_pr : PR_LOW;
    end

    res = '0;
    if (!zero_out) begin
      res[ID_LSB +: IDW] = ident;
      res[PRW-1:0]       = prio_mode_i ? pr : PRW'(1);
    end
    top_o = res;

    AST_EMPTY_ZERO: assert (force_en_i || enab != '0 || res == '0); // R3
    AST_WINNER_ENABLED: assert (force_en_i || enab == '0 || enab[res[ID_LSB +: IDW]]); // R2
    AST_CONST_PRIO: assert (prio_mode_i || res == '0 || res[PRW-1:0] == PRW'(1)); // R9
    AST_SPARE_ZERO: assert ((res & ~({{(OUTW-IDW){1'b0}}, {IDW{1'b1}}} << ID_LSB) & ~OUTW'({PRW{1'b1}})) == '0); // R9
    AST_EXT_OVERRIDE: assert (!(force_en_i && enab[EXT_POS] && (force_id_i == EXT_ID || dflt_rel_i))
                              || res[ID_LSB +: IDW] == EXT_ID); // R7
    AST_FORCED_ABSENT: assert (!(force_en_i && !enab[EXT_POS] && force_id_i == EXT_ID) || res == '0); // R6
  end

endmodule

// File: tb/test_vs_top_irq_report.sv
module test_vs_top_irq_report;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] pend, enbl, deleg;
  logic        fen, drel, pmode;
  logic [11:0] fid;
  logic [7:0]  fpr;
  logic [5:0]  gsel;
  logic [63:0] top;

  int n_chk = 0;
  int n_bad = 0;

  vs_top_irq_report i_vs_top_irq_report (
    .pend_i(pend), .enbl_i(enbl), .deleg_i(deleg), .force_en_i(fen),
    .force_id_i(fid), .dflt_rel_i(drel), .prio_mode_i(pmode),
    .force_prio_i(fpr), .guest_ext_sel_i(gsel), .top_o(top)
  );

  function automatic int rank(input int p);
    case (p)
      11: return 0;
      3:  return 1;
      7:  return 2;
      9:  return 3;
      1:  return 4;
      5:  return 5;
      13: return 6;
      default: return 7 + p;
    endcase
  endfunction

  function automatic logic [63:0] model();
    logic [63:0] en;
    logic [7:0]  ep, pr;
    int          id, best;
    en = (pend & enbl & deleg) >> 1;
    ep = (gsel == 0 && fid == 9 && fpr != 0) ? fpr : 8'd255;
    if (fen) begin
      if (!en[9] && fid == 9) return 64'd0;
      id = (en[9] && (fid == 9 || drel)) ? 9 : int'(fid);
      pr = (id == 9) ? ep : ((fpr != 0 || !drel) ? fpr : 8'd255);
    end else begin
      if (en == 0) return 64'd0;
      best = 1000; id = 0;
      for (int i = 0; i < 64; i++)
        if (en[i] && rank(i) < best) begin best = rank(i); id = i; end
      pr = (id == 9) ? ep : 8'd255;
    end
    return (64'(id) << 16) | 64'(pmode ? pr : 8'd1);
  endfunction

  task automatic check(input string req);
    logic [63:0] exp;
    #2;
    exp = model();
    n_chk++;
    if (top !== exp) begin
      n_bad++;
      $display("FAIL %s: top=%h expected=%h", req, top, exp);
    end
  endtask

  task automatic clr();
    pend = 0; enbl = 0; deleg = 0; fen = 0; fid = 0; drel = 0;
    pmode = 0; fpr = 0; gsel = 0;
  endtask

  initial begin
    #20_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr();
    @(negedge clk);
    check("R3 idle");
    if (top !== 64'd0) begin n_bad++; $display("FAIL R3: top=%h expected=0", top); end

    // R1: bit 0 only, missing enable, missing delegation
    pend = 64'd1; enbl = '1; deleg = '1; check("R1 bit0");
    pend = 64'd1 << 4; enbl = ~(64'd1 << 4); check("R1 no enable");
    enbl = '1; deleg = ~(64'd1 << 4); check("R1 no deleg");
    deleg = '1; check("R1 mapped");
    if (top[27:16] !== 12'd3) begin n_bad++; $display("FAIL R1: id=%0d expected=3", top[27:16]); end

    // R2 R4 R9: every single position, both modes
    for (int i = 1; i < 64; i++)
      for (int m = 0; m < 2; m++) begin
        clr(); pend = 64'd1 << i; enbl = '1; deleg = '1; pmode = m[0];
        check("R2 R4 R9 single");
      end

    // R2: all pairs among low positions
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        clr(); pend = (64'd1 << (a + 1)) | (64'd1 << (b + 1));
        enbl = '1; deleg = '1; pmode = 1;
        check("R2 pair");
      end

    // R2: dense patterns with high bits
    for (int s = 0; s < 64; s++) begin
      clr(); pend = {32'h9e3779b9 * s, 32'h7f4a7c15 ^ (s * 32'h1234567)};
      pend = pend & ~(64'h0000_0000_0000_3ffe);
      enbl = '1; deleg = '1; pmode = 1;
      check("R2 dense");
    end

    // R4 R5: external winner with selector and injected priority variants
    for (int g = 0; g < 2; g++)
      for (int f = 0; f < 3; f++)
        for (int d = 0; d < 3; d++) begin
          clr(); pend = 64'd1 << 10; enbl = '1; deleg = '1; pmode = 1;
          gsel = g[0] ? 6'd3 : 6'd0;
          fid = (f == 0) ? 12'd9 : ((f == 1) ? 12'd4 : 12'd0);
          fpr = (d == 0) ? 8'd0 : ((d == 1) ? 8'd5 : 8'd200);
          check("R4 R5 ext prio");
        end

    // R6 R7 R8 R9: override sweep
    for (int e = 0; e < 2; e++)
      for (int f = 0; f < 5; f++)
        for (int r = 0; r < 2; r++)
          for (int d = 0; d < 3; d++)
            for (int g = 0; g < 2; g++)
              for (int m = 0; m < 2; m++) begin
                clr(); fen = 1; enbl = '1; deleg = '1;
                pend = e[0] ? (64'd1 << 10) | (64'd1 << 4) : (64'd1 << 4);
                case (f)
                  0: fid = 12'd9;
                  1: fid = 12'd0;
                  2: fid = 12'd3;
                  3: fid = 12'd13;
                  default: fid = 12'd100;
                endcase
                drel = r[0]; gsel = g[0] ? 6'd1 : 6'd0; pmode = m[0];
                fpr = (d == 0) ? 8'd0 : ((d == 1) ? 8'd7 : 8'd255);
                check("R6 R7 R8 R9 override");
              end

    // R6: explicit zero when forced external absent
    clr(); fen = 1; fid = 12'd9; fpr = 8'd40; pmode = 1; enbl = '1; deleg = '1;
    pend = 64'd1 << 9; check("R6 absent ext");
    // R8: zero priority relative placement gives 255
    clr(); fen = 1; fid = 12'd6; drel = 1; pmode = 1; check("R8 zero prio");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule